// File: doc/BRIEF.md
# Burst-of-two quad-data-rate SRAM model

This block is a synthesizable behavioural model of a quad-data-rate static RAM whose accesses are all two-beat bursts. The read port and the write port run independently, each with its own data bus, but both take their address from one shared bus. Time inside the model runs on a single clock `clk` whose rising edges are the half-periods of the device clock. The first rising edge after reset is a K edge. After that, K# and K edges alternate. Read data is returned on the same edge stream, which is the single-clock arrangement.

A read is requested by pulling `rd_n` low at a K edge. The address is taken on that same edge. The two words of the pair are returned in order, even word first, on consecutive edges. In place of a tristate driver, an enable output marks the edges on which `q` carries data.

A write is requested by pulling `wr_n` low at a K edge, and the first beat of data is captured on that edge. On the following K# edge the model captures the write address and the second beat, then stores both words. Each data lane has its own active-low write select, sampled with the beat it qualifies. The storage is a small register array of `2**(AW+1)` words.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset, `q_oe` is 0 and every word of the array reads as zero.
- R2: When `rd_n` is 0 on a K edge, the even word of the pair at `addr` appears on `q` with `q_oe`=1 on the edge RD_LAT half-periods later (default 3). The odd word follows on the next edge. `q_oe` is 0 on every edge that carries no read beat.
- R3: `rd_n` and `addr` sampled on a K# edge never start a read.
- R4: When `wr_n` is 0 on a K edge, `d` on that edge is stored at word `{addr,0}`, and `d` on the next K# edge is stored at word `{addr,1}`, where `addr` is the value sampled on that K# edge.
- R5: When `wr_n` is 1 on a K edge, the `d`, `lane_n` and `addr` values of that K cycle leave the array unchanged.
- R6: Lane i covers bits `[i*LANE_W +: LANE_W]`. A lane is written only if its `lane_n` bit is 0 on the edge of its beat; a lane whose bit is 1 keeps its old contents.
- R7: A read beat driven on the same K# edge where a write to its word is stored returns the newly written lanes merged with the old contents of the masked lanes.
- R8: Reads on consecutive K edges produce an unbroken run of beats, returned in command order.
- R9: A read and a write issued in the same K cycle to different addresses both complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period clock; rising edges alternate K, K# starting with K |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Read request, active low, sampled on K edges |
| wr_n | input | 1 | Write request, active low, sampled on K edges |
| addr | input | AW | Shared address: the read address on K edges, the write address on K# edges |
| d | input | LANE_W*LANES | Write data, one beat per edge |
| lane_n | input | LANES | Per-lane write selects, active low, one per beat |
| q | output | LANE_W*LANES | Read data beat |
| q_oe | output | 1 | High when `q` carries a read beat |

## Verification
A read beat and a write commit can fall on the same K# edge, and both can touch the same word. The bench sets this up by issuing a read on one K edge and a write to the same address two edges later. With the default latency, the even beat of the read then leaves on exactly the edge where the write is stored. Partial lane masks are used so that the expected beat is a mix of new and old lanes. The scoreboard computes that mix from its own array, updated in edge order, and compares it with `q`. Randomised traffic then mixes overlapping reads and writes to a few addresses.

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
  parameter int AW     = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int RD_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANE_W*LANES-1:0] d,
  input  logic [LANES-1:0]        lane_n,
  output logic [LANE_W*LANES-1:0] q,
  output logic                    q_oe
);
  localparam int DW    = LANE_W * LANES;
  localparam int WORDS = 2 ** (AW + 1);

  logic             ph;
  logic [DW-1:0]    mem [WORDS];
  logic             wpend;
  logic [DW-1:0]    wd0;
  logic [LANES-1:0] wm0;
  logic [RD_LAT-1:0] p_v;
  logic [AW-1:0]    p_a [RD_LAT];
  logic             b1_v;
  logic [AW-1:0]    b1_a;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] msk_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++)
      if (!msk_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  wire           commit = ph && wpend;
  wire           beat0  = p_v[RD_LAT-1];
  wire [AW-1:0]  rd_a   = beat0 ? p_a[RD_LAT-1] : b1_a;
  wire           rd_b   = !beat0;
  wire [DW-1:0]  rd_raw = mem[{rd_a, rd_b}];
  wire           fwd    = commit && (addr == rd_a);
  wire [DW-1:0]  rd_val = !fwd ? rd_raw :
                          (rd_b ? merge(rd_raw, d, lane_n) : merge(rd_raw, wd0, wm0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      wpend <= 1'b0;
      wd0   <= '0;
      wm0   <= '1;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        wpend <= !wr_n;
        wd0   <= d;
        wm0   <= lane_n;
      end else begin
        wpend <= 1'b0;
      end
      if (commit) begin
        mem[{addr, 1'b0}] <= merge(mem[{addr, 1'b0}], wd0, wm0);
        mem[{addr, 1'b1}] <= merge(mem[{addr, 1'b1}], d, lane_n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v  <= '0;
      b1_v <= 1'b0;
      b1_a <= '0;
      q    <= '0;
      q_oe <= 1'b0;
      for (int s = 0; s < RD_LAT; s++) p_a[s] <= '0;
    end else begin
      p_v[0] <= !ph && !rd_n;
      p_a[0] <= addr;
      for (int s = 1; s < RD_LAT; s++) begin
        p_v[s] <= p_v[s-1];
        p_a[s] <= p_a[s-1];
      end
      b1_v <= beat0;
      b1_a <= p_a[RD_LAT-1];
      q_oe <= beat0 || b1_v;
      q    <= (beat0 || b1_v) ? rd_val : '0;
    end
  end

  AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |=> q_oe); // R2

  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph && !wpend) |=> mem[{$past(addr), 1'b0}] == $past(mem[{addr, 1'b0}])); // R5

  AST_NO_COMMIT_ON_K: assert property (@(posedge clk) disable iff (!rst_n)
    !ph |=> mem[{$past(addr), 1'b1}] == $past(mem[{addr, 1'b1}])); // R4

  AST_MASKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (&lane_n)) |=> mem[{$past(addr), 1'b1}] == $past(mem[{addr, 1'b1}])); // R6
endmodule

// File: tb/tb_qdr_b2_sram.sv
module tb_qdr_b2_sram;
  localparam int PERIOD = 10;
  localparam int AW = 4, LW = 9, LN = 2, LAT = 3;
  localparam int DW = LW * LN;

  logic clk = 0, rst_n = 0, rd_n = 1, wr_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d = '0;
  logic [LN-1:0] lane_n = '1;
  logic [DW-1:0] q;
  logic q_oe;

  qdr_b2_sram #(.AW(AW), .LANE_W(LW), .LANES(LN), .RD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .d(d), .lane_n(lane_n), .q(q), .q_oe(q_oe));

  always #(PERIOD/2) clk = ~clk;

  typedef struct { int due; int word; string tag; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] ref_mem [2**(AW+1)];
  int errors = 0, checks = 0, drv_edge = 0, mon_edge = 0;
  bit started = 0, wp = 0;
  logic [DW-1:0] rd0;
  logic [LN-1:0] rm0;
  string cur_tag = "R2";

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                        input logic [LN-1:0] mn);
    logic [DW-1:0] r;
    r = o;
    for (int l = 0; l < LN; l++) if (!mn[l]) r[l*LW +: LW] = n[l*LW +: LW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (edge %0d)", tag, act, ex, mon_edge);
    end
  endtask

  task automatic half(input logic r, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] dd, input logic [LN-1:0] m);
    rd_n = r; wr_n = w; addr = a; d = dd; lane_n = m;
    if (drv_edge % 2 == 0) begin
      if (!r) begin
        exp_q.push_back('{drv_edge + LAT,     int'({a, 1'b0}), cur_tag});
        exp_q.push_back('{drv_edge + LAT + 1, int'({a, 1'b1}), cur_tag});
      end
      wp = !w; rd0 = dd; rm0 = m;
    end else if (wp) begin
      ref_mem[{a, 1'b0}] = mrg(ref_mem[{a, 1'b0}], rd0, rm0);
      ref_mem[{a, 1'b1}] = mrg(ref_mem[{a, 1'b1}], dd, m);
      wp = 0;
    end
    @(negedge clk);
    drv_edge++;
  endtask

  task automatic cyc(input logic r, input logic w, input logic [AW-1:0] ra,
                     input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                     input logic [LN-1:0] m0, input logic [DW-1:0] d1,
                     input logic [LN-1:0] m1);
    half(r, w, ra, d0, m0);
    half(1'b1, 1'b1, wa, d1, m1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, '0, '0, '0, '1, '0, '1);
  endtask

  always @(posedge clk) begin
    if (started) begin
      #2;
      if (exp_q.size() > 0 && exp_q[0].due == mon_edge) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(q_oe === 1'b1 && q === ref_mem[e.word], e.tag, {q_oe, q},
            {1'b1, ref_mem[e.word]});
      end else begin
        chk(q_oe === 1'b0, "R2 idle oe", {{(DW){1'b0}}, q_oe}, '0);
      end
      mon_edge++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 2**(AW+1); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(q_oe === 1'b0, "R1 reset oe", {{(DW){1'b0}}, q_oe}, '0);
    rst_n = 1; started = 1;
    cur_tag = "R1"; cyc(0, 1, 5, 0, 0, '1, 0, '1); idle(3);
    cur_tag = "R4"; cyc(1, 0, 0, 3, 18'h1A5A5, 2'b00, 18'h05A5A, 2'b00); idle(1);
    cur_tag = "R2"; cyc(0, 1, 3, 0, 0, '1, 0, '1); idle(3);
    cur_tag = "R6"; cyc(1, 0, 0, 3, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01); idle(1);
    cyc(0, 1, 3, 0, 0, '1, 0, '1); idle(3);
    cur_tag = "R5"; cyc(1, 1, 3, 3, 18'h00777, 2'b00, 18'h00777, 2'b00); idle(1);
    cyc(0, 1, 3, 0, 0, '1, 0, '1); idle(3);
    cur_tag = "R3"; half(1, 1, 3, 0, '1); half(0, 1, 3, 0, '1); idle(4);
    cur_tag = "R8"; cyc(1, 0, 0, 1, 18'h11111, 2'b00, 18'h22222, 2'b00);
    cyc(1, 0, 0, 2, 18'h12345, 2'b00, 18'h2BCDE, 2'b00);
    cyc(0, 1, 1, 0, 0, '1, 0, '1); cyc(0, 1, 2, 0, 0, '1, 0, '1);
    cyc(0, 1, 3, 0, 0, '1, 0, '1); idle(3);
    cur_tag = "R9"; cyc(0, 0, 7, 9, 18'h0F0F0, 2'b00, 18'h30303, 2'b00); idle(1);
    cyc(0, 1, 9, 0, 0, '1, 0, '1); idle(3);
    cur_tag = "R7"; cyc(0, 1, 3, 0, 0, '1, 0, '1);
    cyc(1, 0, 0, 3, 18'h2AAAA, 2'b01, 18'h15555, 2'b00); idle(3);
    cyc(0, 1, 2, 0, 0, '1, 0, '1);
    cyc(1, 0, 0, 2, 18'h3C3C3, 2'b00, 18'h0C3C3, 2'b10); idle(3);
    cur_tag = "R7 random";
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[1], AW'(lf[3:2]), AW'(lf[5:4]), {lf, lf[1:0]}, lf[7:6],
          {lf[1:0], ~lf}, lf[9:8]);
    end
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule